// File: doc/BRIEF.md
# NAND Bus Cycle Timing Sequencer

This block produces the pin-level strobe sequence for a single access to an external NAND flash device. An access is a command byte, an address byte, or a data transfer. Each access is either a read or a write. The caller provides a packed 32-bit timing word and two small turnaround delays. The block then runs the access through three phases in a fixed order: setup, strobe (wait) and hold. During these phases it drives the chip enable, the command and address latch enables, the write and read strobes, and the output enable of the data bus.

The timing word, turnaround delays and control bits are held by a register file outside this block. After reset that register file loads 0x0A0A0A0A, which gives ten cycles for every phase. The sequencer latches the phase lengths when it accepts a request, so a change to the configuration during an access does not alter that access. Three controls shape the access. With wait support on, a busy device stretches the strobe phase. The bus-width control selects 8-bit or 16-bit data transfers. A bank-enable bit gates every new request.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset the device pins are idle: chip enable, write strobe and read strobe are high (inactive), both latch enables are low, no data lane is driven, done is low and req_ready is high.
- R2: An accepted access runs a setup phase, then a strobe phase, then a hold phase. Their lengths in cycles come from timing word bits 7:0, 15:8 and 23:16, and a field value of 0 is treated as 1.
- R3: Chip enable is low through all three phases. A write holds the write strobe low only during the strobe phase. A read does the same with the read strobe. The two strobes are never low together.
- R4: Request kind 0 is a command byte and raises the command latch enable for the whole access. Kind 1 is an address byte and raises the address latch enable. Kinds 2 and 3 are data transfers and raise neither.
- R5: On a write, data lane 0 is driven from cycle hiz+1 of the strobe phase (0-based), where hiz is timing word bits 31:24, through the last hold cycle. If that cycle falls beyond the strobe phase, driving starts with the first hold cycle. A read never drives the bus.
- R6: When cfg_width is 1, a data transfer drives both lanes and a read captures all 16 bits. Command and address bytes always use lane 0 only. An 8-bit read returns zero in the upper byte.
- R7: For a read that directly follows an accepted command access, the setup phase lasts max(setup, cle_re+1) cycles. If the previous access was an address access, it lasts max(setup, ale_re+1) cycles. A read after a data access uses the plain setup length.
- R8: With cfg_wait_en high, a low rb_n in the last strobe cycle stretches the strobe phase until the cycle in which rb_n is seen high.
- R9: With cfg_wait_en low, rb_n has no effect on the strobe-phase length.
- R10: done pulses high for exactly one cycle, in the cycle after the last hold cycle. req_ready is high only while the block is idle. A request raised while an access is in progress is ignored.
- R11: While cfg_bank_en is low, requests are ignored and the chip enable stays high.
- R12: A read samples nand_dq_i in the last strobe cycle and presents that value on rd_data after the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_timing | input | 32 | Setup, strobe, hold and release fields |
| cfg_cle_re | input | 4 | Command-latch to read-strobe turnaround |
| cfg_ale_re | input | 4 | Address-latch to read-strobe turnaround |
| cfg_wait_en | input | 1 | Honour rb_n during the strobe phase |
| cfg_bank_en | input | 1 | Allow new accesses |
| cfg_width | input | 2 | Data width: 1 = 16-bit, other values 8-bit |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 command, 1 address, 2/3 data |
| req_write | input | 1 | 1 write, 0 read |
| req_data | input | 16 | Byte or word to write |
| req_ready | output | 1 | Idle, a request will be taken |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data captured by the last read |
| rb_n | input | 1 | Device ready (high) / busy (low) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 16 | Data bus out |
| nand_dq_oe | output | 2 | Per-byte-lane output enable |
| nand_dq_i | input | 16 | Data bus in |

## Verification
The bench counts the cycles of each phase separately. An off-by-one counter reload, or a zero field that slips through the floor to one, therefore shows up as a wrong setup, strobe or hold count instead of a merely wrong total. It checks the read turnaround after a command, after an address and after a data access, with delays both above and below the setup length. A design that forgets the previous access kind either stretches every read or never stretches one. It places the bus-drive start on both sides of the strobe/hold boundary, including hiz=0, to catch comparisons that are one cycle early or late. It also releases rb_n partway through a stretched strobe phase, with wait support on and off, and injects a request mid-access. A design that samples rb_n in the wrong cycle, or that takes requests while busy, fails these checks.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   typedef logic [1:0] kind_t;

   localparam kind_t KIND_CMD  = 2'd0;
   localparam kind_t KIND_ADDR = 2'd1;
   localparam kind_t KIND_DATA = 2'd2;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_WAIT  = 2'd2,
      PH_HOLD  = 2'd3
   } phase_t;

   function automatic logic is_data_kind(input kind_t k);
      return k[1];
   endfunction

endpackage

// File: rtl/nand_phase_ctl.sv
module nand_phase_ctl
   import nand_seq_pkg::*;
#(
   parameter int FIELD_W = 8,
   parameter int DLY_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               start_read,
   input  kind_t              start_kind,
   input  logic [FIELD_W-1:0] setup_len,
   input  logic [FIELD_W-1:0] wait_len,
   input  logic [FIELD_W-1:0] hold_len,
   input  logic [DLY_W-1:0]   cle_dly,
   input  logic [DLY_W-1:0]   ale_dly,
   input  logic               wait_en,
   input  logic               rb_n,
   output phase_t             phase,
   output logic               done,
   output logic               wait_last
);

   if (FIELD_W < DLY_W + 1) begin : g_bad_width
      $error("nand_phase_ctl: FIELD_W must exceed DLY_W");
   end

   localparam logic [FIELD_W-1:0] ONE = FIELD_W'(1);

   function automatic logic [FIELD_W-1:0] floor1(input logic [FIELD_W-1:0] v);
      return (v == '0) ? ONE : v;
   endfunction

   logic [FIELD_W-1:0] cnt;
   logic [FIELD_W-1:0] wait_q;
   logic [FIELD_W-1:0] hold_q;
   kind_t              prev_q;
   logic [FIELD_W-1:0] turn_len;
   logic [FIELD_W-1:0] setup_eff;
   logic [FIELD_W-1:0] first_len;
   logic               released;

   always_comb begin
      turn_len = '0;
      if (start_read) begin
         if (prev_q == KIND_CMD) begin
            turn_len = FIELD_W'(cle_dly) + ONE;
         end else if (prev_q == KIND_ADDR) begin
            turn_len = FIELD_W'(ale_dly) + ONE;
         end
      end
      setup_eff = floor1(setup_len);
      first_len = (turn_len > setup_eff) ? turn_len : setup_eff;
   end

   assign released  = !(wait_en && !rb_n);
   assign wait_last = (phase == PH_WAIT) && (cnt == '0) && released;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
         wait_q <= ONE;
         hold_q <= ONE;
         prev_q <= KIND_DATA;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase  <= PH_SETUP;
                  cnt    <= first_len - ONE;
                  wait_q <= floor1(wait_len);
                  hold_q <= floor1(hold_len);
                  prev_q <= is_data_kind(start_kind) ? KIND_DATA : start_kind;
               end
            end
            PH_SETUP: begin
               if (cnt == '0) begin
                  phase <= PH_WAIT;
                  cnt   <= wait_q - ONE;
               end else begin
                  cnt <= cnt - ONE;
               end
            end
            PH_WAIT: begin
               if (cnt == '0) begin
                  if (released) begin
                     phase <= PH_HOLD;
                     cnt   <= hold_q - ONE;
                  end
               end else begin
                  cnt <= cnt - ONE;
               end
            end
            PH_HOLD: begin
               if (cnt == '0) begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt - ONE;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R8: a busy device at the end of the strobe phase keeps the strobe phase
   p_wait_stretch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT && cnt == '0 && wait_en && !rb_n) |=> (phase == PH_WAIT));

   // R2: phases only ever advance setup -> strobe -> hold -> idle
   p_phase_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HOLD) |=> (phase == PH_HOLD || phase == PH_IDLE));

endmodule

// File: rtl/nand_oe_gen.sv
module nand_oe_gen
   import nand_seq_pkg::*;
#(
   parameter int FIELD_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  phase_t             phase,
   input  logic               is_write,
   input  logic [FIELD_W-1:0] hiz_len,
   output logic               drive
);

   localparam int EL_W = FIELD_W + 1;
   localparam logic [EL_W-1:0] EL_MAX = {EL_W{1'b1}};

   logic [EL_W-1:0] elapsed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed <= '0;
      end else if (phase != PH_WAIT) begin
         elapsed <= '0;
      end else if (elapsed != EL_MAX) begin
         elapsed <= elapsed + EL_W'(1);
      end
   end

   assign drive = is_write &&
                  (((phase == PH_WAIT) && (elapsed > EL_W'(hiz_len))) ||
                   (phase == PH_HOLD));

endmodule

// File: rtl/nand_pin_drv.sv
module nand_pin_drv
   import nand_seq_pkg::*;
#(
   parameter int DQ_W  = 16,
   parameter int LANES = DQ_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  phase_t           phase,
   input  kind_t            kind,
   input  logic             is_write,
   input  logic             wide,
   input  logic             drive,
   input  logic             wait_last,
   input  logic [DQ_W-1:0]  wr_data,
   input  logic [DQ_W-1:0]  dq_i,
   output logic             ce_n,
   output logic             cle,
   output logic             ale,
   output logic             we_n,
   output logic             re_n,
   output logic [DQ_W-1:0]  dq_o,
   output logic [LANES-1:0] dq_oe,
   output logic [DQ_W-1:0]  rd_data
);

   logic active;
   logic capture;

   assign active  = (phase != PH_IDLE);
   assign ce_n    = !active;
   assign cle     = active && (kind == KIND_CMD);
   assign ale     = active && (kind == KIND_ADDR);
   assign we_n    = !((phase == PH_WAIT) && is_write);
   assign re_n    = !((phase == PH_WAIT) && !is_write);
   assign dq_o    = wr_data;
   assign capture = wait_last && !is_write;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic       lane_en;
      logic [7:0] q;
      if (l == 0) begin : g_base
         assign lane_en = 1'b1;
      end else begin : g_upper
         assign lane_en = wide && is_data_kind(kind);
      end
      assign dq_oe[l] = drive && lane_en;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (capture) begin
            q <= lane_en ? dq_i[l*8 +: 8] : 8'h00;
         end
      end
      assign rd_data[l*8 +: 8] = q;
   end

   // R4: never both latch enables
   p_one_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));

   // R3: a strobe only inside an enabled cycle, never both strobes
   p_strobe_in_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n || !re_n) |-> !ce_n);
   p_no_dual_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n));

   // R5: the bus is never driven while the read strobe is low
   p_no_drive_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe != '0) |-> re_n);

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
   import nand_seq_pkg::*;
#(
   parameter int FIELD_W = 8,
   parameter int DLY_W   = 4,
   parameter int DQ_W    = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [4*FIELD_W-1:0] cfg_timing,
   input  logic [DLY_W-1:0]     cfg_cle_re,
   input  logic [DLY_W-1:0]     cfg_ale_re,
   input  logic                 cfg_wait_en,
   input  logic                 cfg_bank_en,
   input  logic [1:0]           cfg_width,
   input  logic                 req_valid,
   input  logic [1:0]           req_kind,
   input  logic                 req_write,
   input  logic [DQ_W-1:0]      req_data,
   output logic                 req_ready,
   output logic                 done,
   output logic [DQ_W-1:0]      rd_data,
   input  logic                 rb_n,
   output logic                 nand_ce_n,
   output logic                 nand_cle,
   output logic                 nand_ale,
   output logic                 nand_we_n,
   output logic                 nand_re_n,
   output logic [DQ_W-1:0]      nand_dq_o,
   output logic [DQ_W/8-1:0]    nand_dq_oe,
   input  logic [DQ_W-1:0]      nand_dq_i
);

   localparam int LANES = DQ_W / 8;

   if ((DQ_W % 8) != 0 || LANES < 1 || LANES > 2) begin : g_bad_dq
      $error("nand_cycle_seq: DQ_W must be 8 or 16");
   end

   phase_t             phase;
   logic               start;
   logic               wait_last;
   logic               drive;
   kind_t              kind_q;
   logic               write_q;
   logic               wide_q;
   logic [DQ_W-1:0]    data_q;
   logic [FIELD_W-1:0] f_setup, f_wait, f_hold, f_hiz;
   logic [FIELD_W-1:0] hiz_q;

   assign f_setup   = cfg_timing[0*FIELD_W +: FIELD_W];
   assign f_wait    = cfg_timing[1*FIELD_W +: FIELD_W];
   assign f_hold    = cfg_timing[2*FIELD_W +: FIELD_W];
   assign f_hiz     = cfg_timing[3*FIELD_W +: FIELD_W];

   assign req_ready = (phase == PH_IDLE);
   assign start     = req_valid && req_ready && cfg_bank_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= KIND_DATA;
         write_q <= 1'b0;
         wide_q  <= 1'b0;
         data_q  <= '0;
         hiz_q   <= '0;
      end else if (start) begin
         kind_q  <= req_kind;
         write_q <= req_write;
         wide_q  <= (cfg_width == 2'd1) && (LANES > 1);
         data_q  <= req_data;
         hiz_q   <= f_hiz;
      end
   end

   nand_phase_ctl #(.FIELD_W(FIELD_W), .DLY_W(DLY_W)) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_read (!req_write),
      .start_kind (req_kind),
      .setup_len  (f_setup),
      .wait_len   (f_wait),
      .hold_len   (f_hold),
      .cle_dly    (cfg_cle_re),
      .ale_dly    (cfg_ale_re),
      .wait_en    (cfg_wait_en),
      .rb_n       (rb_n),
      .phase      (phase),
      .done       (done),
      .wait_last  (wait_last)
   );

   nand_oe_gen #(.FIELD_W(FIELD_W)) u_oe (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase    (phase),
      .is_write (write_q),
      .hiz_len  (hiz_q),
      .drive    (drive)
   );

   nand_pin_drv #(.DQ_W(DQ_W), .LANES(LANES)) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase     (phase),
      .kind      (kind_q),
      .is_write  (write_q),
      .wide      (wide_q),
      .drive     (drive),
      .wait_last (wait_last),
      .wr_data   (data_q),
      .dq_i      (nand_dq_i),
      .ce_n      (nand_ce_n),
      .cle       (nand_cle),
      .ale       (nand_ale),
      .we_n      (nand_we_n),
      .re_n      (nand_re_n),
      .dq_o      (nand_dq_o),
      .dq_oe     (nand_dq_oe),
      .rd_data   (rd_data)
   );

   // R10: completion is a single-cycle pulse
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: an accepted request enables the device on the next cycle
   p_start_enables_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && cfg_bank_en) |=> !nand_ce_n);

   // R11: with the bank off an idle block stays idle
   p_bank_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (nand_ce_n && !cfg_bank_en) |=> nand_ce_n);

endmodule

// File: tb/sim_nand_cycle_seq.sv
module sim_nand_cycle_seq;

   typedef struct packed {
      logic [31:0] timing;
      logic [3:0]  cle_re;
      logic [3:0]  ale_re;
      logic [1:0]  kind;
      logic        wr;
      logic        wide;
      int          exp_s;
      int          exp_w;
      int          exp_h;
      int          exp_oe;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t TBL [NV] = '{
      '{32'h0A0A0A0A, 4'hF, 4'hF, 2'd0, 1'b1, 1'b0, 10, 10, 10, 10},
      '{32'h01030402, 4'hF, 4'hF, 2'd1, 1'b1, 1'b0,  2,  4,  3,  2},
      '{32'h01020305, 4'hF, 4'hF, 2'd2, 1'b1, 1'b1,  5,  3,  2,  2},
      '{32'h00010101, 4'hF, 4'hF, 2'd2, 1'b1, 1'b0,  1,  1,  1,  1},
      '{32'h02050601, 4'hF, 4'hF, 2'd2, 1'b0, 1'b0,  1,  6,  5, -1},
      '{32'h00000000, 4'hF, 4'hF, 2'd3, 1'b1, 1'b0,  1,  1,  1,  1},
      '{32'h01020302, 4'h5, 4'hF, 2'd0, 1'b1, 1'b0,  2,  3,  2,  2},
      '{32'h01020302, 4'h5, 4'hF, 2'd2, 1'b0, 1'b1,  6,  3,  2, -1},
      '{32'h01020302, 4'h5, 4'h0, 2'd1, 1'b1, 1'b0,  2,  3,  2,  2},
      '{32'h01020302, 4'h5, 4'h0, 2'd2, 1'b0, 1'b0,  2,  3,  2, -1},
      '{32'h01020302, 4'h5, 4'h9, 2'd1, 1'b1, 1'b0,  2,  3,  2,  2},
      '{32'h01020302, 4'h5, 4'h9, 2'd2, 1'b0, 1'b1, 10,  3,  2, -1},
      '{32'h01020302, 4'h5, 4'h9, 2'd2, 1'b0, 1'b0,  2,  3,  2, -1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_timing = 32'h0A0A0A0A;
   logic [3:0]  cfg_cle_re = 4'hF;
   logic [3:0]  cfg_ale_re = 4'hF;
   logic        cfg_wait_en = 1'b0;
   logic        cfg_bank_en = 1'b1;
   logic [1:0]  cfg_width = 2'd0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'd0;
   logic        req_write = 1'b0;
   logic [15:0] req_data = '0;
   logic        req_ready;
   logic        done;
   logic [15:0] rd_data;
   logic        rb_n = 1'b1;
   logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
   logic [15:0] nand_dq_o;
   logic [1:0]  nand_dq_oe;
   logic [15:0] nand_dq_i = '0;

   int total = 0;
   int bad = 0;

   int m_s, m_w, m_h, m_oe;
   bit m_cle, m_ale, m_hi, m_fin;
   logic [15:0] m_dq;

   always #5 clk = ~clk;

   nand_cycle_seq u0 (
      .clk(clk), .rst_n(rst_n), .cfg_timing(cfg_timing),
      .cfg_cle_re(cfg_cle_re), .cfg_ale_re(cfg_ale_re),
      .cfg_wait_en(cfg_wait_en), .cfg_bank_en(cfg_bank_en),
      .cfg_width(cfg_width), .req_valid(req_valid), .req_kind(req_kind),
      .req_write(req_write), .req_data(req_data), .req_ready(req_ready),
      .done(done), .rd_data(rd_data), .rb_n(rb_n),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
      .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i)
   );

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Issue one request and classify every enabled cycle until done.
   task automatic run_access(input logic [1:0] kind, input logic wr,
                             input logic [15:0] wdata,
                             input int release_at, input int inject_at);
      int tot;
      @(negedge clk);
      req_kind = kind; req_write = wr; req_data = wdata; req_valid = 1'b1;
      m_s = 0; m_w = 0; m_h = 0; m_oe = -1;
      m_cle = 0; m_ale = 0; m_hi = 0; m_fin = 0; m_dq = '0;
      tot = 0;
      for (int it = 0; it < 3000 && !m_fin; it++) begin
         @(negedge clk);
         req_valid = 1'b0;
         if (inject_at != 0 && tot == inject_at) begin
            req_valid = 1'b1; req_kind = 2'd1; req_write = 1'b1;
         end
         if (done) begin
            m_fin = 1;
         end else if (!nand_ce_n) begin
            if (nand_dq_oe[0] && m_oe < 0) begin
               m_oe = tot; m_dq = nand_dq_o;
            end
            if (nand_dq_oe[1]) m_hi = 1;
            if (nand_cle) m_cle = 1;
            if (nand_ale) m_ale = 1;
            if (!nand_we_n || !nand_re_n) m_w++;
            else if (m_w == 0) m_s++;
            else m_h++;
            tot++;
            if (release_at != 0 && tot == release_at) rb_n = 1'b1;
         end
      end
      req_valid = 1'b0;
      if (!m_fin) check("R10", "access never completed", 0, 1);
   endtask

   task automatic idle_quiet(input string req, input int n);
      int seen;
      seen = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (!nand_ce_n || done) seen++;
      end
      check(req, "activity while it should stay idle", seen, 0);
   endtask

   initial begin
      #2000000;
      $display("FAIL watchdog: run did not finish");
      bad++; total++;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: pin state in reset and right after
      check("R1", "ce_n in reset", nand_ce_n, 1);
      check("R1", "we_n/re_n in reset", {nand_we_n, nand_re_n}, 2'b11);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "latch enables", {nand_cle, nand_ale}, 0);
      check("R1", "dq_oe", nand_dq_oe, 0);
      check("R1", "done", done, 0);
      check("R1", "req_ready", req_ready, 1);

      // Table walk: R2 R3 R4 R5 R6 R7 R12
      for (int i = 0; i < NV; i++) begin
         logic [15:0] wdat, pat, exp_rd;
         bit is_data;
         cfg_timing = TBL[i].timing;
         cfg_cle_re = TBL[i].cle_re;
         cfg_ale_re = TBL[i].ale_re;
         cfg_width  = TBL[i].wide ? 2'd1 : 2'd0;
         pat  = {8'(8'h40 + i), 8'(8'hC0 + i)};
         wdat = {8'(8'h90 + i), 8'(8'h10 + i)};
         nand_dq_i = pat;
         is_data = TBL[i].kind[1];
         run_access(TBL[i].kind, TBL[i].wr, wdat, 0, 0);
         check("R2/R7", $sformatf("v%0d setup cycles", i), m_s, TBL[i].exp_s);
         check("R2/R3", $sformatf("v%0d strobe cycles", i), m_w, TBL[i].exp_w);
         check("R2", $sformatf("v%0d hold cycles", i), m_h, TBL[i].exp_h);
         check("R4", $sformatf("v%0d cle", i), m_cle, TBL[i].kind == 2'd0);
         check("R4", $sformatf("v%0d ale", i), m_ale, TBL[i].kind == 2'd1);
         if (TBL[i].exp_oe < 0) begin
            check("R5", $sformatf("v%0d read drove bus", i), m_oe, -1);
         end else begin
            check("R5", $sformatf("v%0d drive start", i), m_oe - m_s, TBL[i].exp_oe);
            check("R5", $sformatf("v%0d low byte", i), m_dq[7:0], wdat[7:0]);
         end
         check("R6", $sformatf("v%0d upper lane", i), m_hi,
               TBL[i].wr && TBL[i].wide && is_data);
         if (!TBL[i].wr) begin
            exp_rd = (TBL[i].wide && is_data) ? pat : {8'h00, pat[7:0]};
            check("R12/R6", $sformatf("v%0d rd_data", i), rd_data, exp_rd);
         end
      end

      // R8: busy device stretches the strobe phase until released
      cfg_timing = 32'h01020302; cfg_width = 2'd0;
      cfg_wait_en = 1'b1; rb_n = 1'b0;
      run_access(2'd2, 1'b1, 16'h1234, 9, 0);
      check("R8", "stretched strobe cycles", m_w, 7);
      check("R8", "hold after stretch", m_h, 2);

      // R9: rb_n ignored when wait support is off
      cfg_wait_en = 1'b0; rb_n = 1'b0;
      run_access(2'd2, 1'b1, 16'h1234, 0, 0);
      check("R9", "strobe cycles with busy ignored", m_w, 3);
      rb_n = 1'b1;

      // R10: request during an access is ignored
      cfg_timing = 32'h01040404;
      run_access(2'd0, 1'b1, 16'h0070, 0, 5);
      check("R10", "no address latch from injected request", m_ale, 0);
      check("R10", "strobe cycles of original access", m_w, 4);
      idle_quiet("R10", 10);

      // R10: done lasts one cycle
      run_access(2'd2, 1'b1, 16'h0001, 0, 0);
      @(negedge clk);
      check("R10", "done after one cycle", done, 0);
      check("R10", "ready when idle", req_ready, 1);

      // R11: bank disabled blocks requests
      cfg_bank_en = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'd0; req_write = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      idle_quiet("R11", 20);
      cfg_bank_en = 1'b1;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule